// File: doc/BRIEF.md
# Embedded Line and Frame Code Inserter

This block sits downstream of a pixel byte sequencer and overwrites blanking bytes around each horizontal active window with four-byte timing markers. A receiver can then find line and frame boundaries in the byte stream alone, without separate horizontal and vertical sync wires. Every marker is a preamble of 0xFF, 0x00, 0x00 followed by one code byte. The bytes inside the active window are never altered. All other bytes pass through with a fixed delay of four clock cycles. That delay lets a start marker land in the four slots just before the first window byte.

Two marker styles are available. The compact style uses four code values and marks active lines only. The flagged style builds the code byte from a vertical-blanking bit and a start/end bit, and marks every line, including vertical blanking lines. A frame-sync pulse latches the style and the on/off setting once per frame. The upstream sequencer has to leave at least eight non-window bytes between two consecutive windows. Each line's flags have to stay steady from the end of the previous window until the end of that line's own window.

Top module: `sci_top`

## Requirements
- R1: While reset is held, and after it is released until stream data arrives, `out_byte` is 0x00 and `out_is_code` is 0.
- R2: Every output slot not taken by a marker carries the input byte from exactly four clock cycles earlier. Window bytes are always passed through unmodified.
- R3: A marker is exactly four consecutive slots with `out_is_code` high: 0xFF, 0x00, 0x00, then the code byte. `out_is_code` is low on every other slot.
- R4: A start marker fills the four output slots directly before the first byte of a window.
- R5: An end marker fills the four output slots directly after the last byte of a window.
- R6: In compact style (`cfg_mode_flag`=0), the start code is 0x00 and the end code is 0x01. Windows on lines with `in_act_line`=0 get no markers.
- R7: In compact style, a line flagged first (`in_first_line`=1) starts with 0x02 instead of 0x00. A line flagged last (`in_last_line`=1) ends with 0x03 instead of 0x01. A single active line flagged both uses 0x02 and 0x03.
- R8: In flagged style (`cfg_mode_flag`=1), every window gets both markers. The code byte is bit7=1, bit6=0, bit5=V, bit4=H, bits3..0=0, where V=1 on lines with `in_act_line`=0 and H=1 for the end marker. This gives 0x80 and 0x90 on active lines and 0xA0 and 0xB0 on blanking lines.
- R9: With insertion disabled (`cfg_ins_en`=0 latched), no marker is produced and the output is the plain four-cycle-delayed input.
- R10: `cfg_ins_en` and `cfg_mode_flag` are taken only on a clock edge where `frame_sync` is high. Changes at any other time have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming stream byte |
| in_win | input | 1 | High on bytes inside the horizontal active window |
| in_act_line | input | 1 | High for the whole of a vertically active line |
| in_first_line | input | 1 | High for the whole of the first active line of a frame |
| in_last_line | input | 1 | High for the whole of the last active line of a frame |
| frame_sync | input | 1 | One-cycle pulse at which the settings are latched |
| cfg_ins_en | input | 1 | Marker insertion on (1) or off (0) |
| cfg_mode_flag | input | 1 | 0 selects compact codes, 1 selects flagged codes |
| out_byte | output | 8 | Delayed stream with markers inserted |
| out_is_code | output | 1 | High on each marker byte |

## Verification
An input byte presented at clock edge n shows up on `out_byte` after edge n+4. A start marker begins right after the edge at which the window's first byte is sampled at the input. An end marker begins right after edge k+5, where k is the edge that sampled the window's last byte. The bench drives one byte at each falling edge. At that same falling edge, before driving, it compares the output against the byte it drove five falling edges earlier. The expected value is built by scanning the driven history up to four slots on either side for window edges. The latched settings are modelled as the values present at the most recent sync pulse, so the code byte and flag are known before the design produces them.

// File: rtl/sci_pkg.sv
`timescale 1ns/1ps
package sci_pkg;

    localparam int BYTE_W   = 8;
    localparam int CODE_LEN = 4;
    localparam int IDX_W    = $clog2(CODE_LEN);

    localparam logic [BYTE_W-1:0] PRE_HEAD = 8'hFF;
    localparam logic [BYTE_W-1:0] PRE_FILL = 8'h00;

    // Payload carried through the alignment delay.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              win;
        logic              act_line;
        logic              last;
    } slot_t;

    // Final byte of a marker.
    //   flagged: 1,0,V,H,0000 with V = blanking line, H = end marker
    //   compact: bit1 = frame edge line, bit0 = end marker
    function automatic logic [BYTE_W-1:0] ref_code(
        input logic flag_mode,
        input logic is_end,
        input logic act_line,
        input logic edge_line
    );
        if (flag_mode)
            ref_code = {1'b1, 1'b0, ~act_line, is_end, 4'b0000};
        else
            ref_code = {6'b000000, edge_line, is_end};
    endfunction

endpackage

// File: rtl/sci_delay.sv
`timescale 1ns/1ps
module sci_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign stg_d[g] = din;
            end else begin : g_body
                assign stg_d[g] = stg_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/sci_cfg.sv
`timescale 1ns/1ps
module sci_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_sync,
    input  logic cfg_ins_en,
    input  logic cfg_mode_flag,
    output logic en,
    output logic flag_mode
);

    typedef struct packed {
        logic en;
        logic flag_mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (frame_sync) begin
            cfg_d.en        = cfg_ins_en;
            cfg_d.flag_mode = cfg_mode_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en        = cfg_q.en;
    assign flag_mode = cfg_q.flag_mode;

endmodule

// File: rtl/sci_seq.sv
`timescale 1ns/1ps
module sci_seq
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flag_mode,
    input  logic              in_win,
    input  logic              in_act_line,
    input  logic              in_first_line,
    input  slot_t             tail,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_is_code
);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] code;
        logic [BYTE_W-1:0] obyte;
        logic              oflag;
        logic              win_in;
        logic              win_out;
        logic              act_out;
        logic              last_out;
    } seq_t;

    seq_t st_d, st_q;
    logic start_hit;
    logic end_hit;

    always_comb begin
        st_d = st_q;

        // window opening seen at the input: four slots remain before it leaves
        start_hit = en && in_win && !st_q.win_in && (flag_mode || in_act_line);
        // window closing seen at the output: next slot is first after it
        end_hit   = en && st_q.win_out && !tail.win && (flag_mode || st_q.act_out);

        st_d.win_in   = in_win;
        st_d.win_out  = tail.win;
        st_d.act_out  = tail.act_line;
        st_d.last_out = tail.last;

        if (st_q.busy) begin
            st_d.oflag = 1'b1;
            if (st_q.idx == IDX_W'(CODE_LEN-1)) begin
                st_d.obyte = st_q.code;
                st_d.busy  = 1'b0;
                st_d.idx   = '0;
            end else begin
                st_d.obyte = PRE_FILL;
                st_d.idx   = st_q.idx + 1'b1;
            end
        end else if (end_hit) begin
            st_d.busy  = 1'b1;
            st_d.idx   = IDX_W'(1);
            st_d.oflag = 1'b1;
            st_d.obyte = PRE_HEAD;
            st_d.code  = ref_code(flag_mode, 1'b1, st_q.act_out, st_q.last_out);
        end else if (start_hit) begin
            st_d.busy  = 1'b1;
            st_d.idx   = IDX_W'(1);
            st_d.oflag = 1'b1;
            st_d.obyte = PRE_HEAD;
            st_d.code  = ref_code(flag_mode, 1'b0, in_act_line, in_first_line);
        end else begin
            st_d.oflag = 1'b0;
            st_d.obyte = tail.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_byte    = st_q.obyte;
    assign out_is_code = st_q.oflag;

endmodule

// File: rtl/sci_top.sv
`timescale 1ns/1ps
module sci_top
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_win,
    input  logic              in_act_line,
    input  logic              in_first_line,
    input  logic              in_last_line,
    input  logic              frame_sync,
    input  logic              cfg_ins_en,
    input  logic              cfg_mode_flag,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_is_code
);

    slot_t slot_in;
    slot_t slot_tail;
    logic  en_lat;
    logic  mode_lat;

    assign slot_in = '{data: in_byte, win: in_win, act_line: in_act_line, last: in_last_line};

    sci_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync   (frame_sync),
        .cfg_ins_en   (cfg_ins_en),
        .cfg_mode_flag(cfg_mode_flag),
        .en           (en_lat),
        .flag_mode    (mode_lat)
    );

    sci_delay #(
        .W    ($bits(slot_t)),
        .DEPTH(CODE_LEN)
    ) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (slot_in),
        .dout (slot_tail)
    );

    sci_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en_lat),
        .flag_mode    (mode_lat),
        .in_win       (in_win),
        .in_act_line  (in_act_line),
        .in_first_line(in_first_line),
        .tail         (slot_tail),
        .out_byte     (out_byte),
        .out_is_code  (out_is_code)
    );

endmodule

// File: rtl/sci_chk.sv
`timescale 1ns/1ps
module sci_chk
    import sci_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] in_byte,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_is_code,
    input logic              en_q
);

    logic [BYTE_W-1:0] dly_q [CODE_LEN+1];
    logic [2:0]        run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= CODE_LEN; i++) dly_q[i] <= '0;
            run_q <= '0;
        end else begin
            dly_q[0] <= in_byte;
            for (int i = 1; i <= CODE_LEN; i++) dly_q[i] <= dly_q[i-1];
            run_q <= out_is_code ? run_q + 3'd1 : 3'd0;
        end
    end

    // R2: non-marker slots are the input delayed by the marker length
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_is_code |-> out_byte == dly_q[CODE_LEN]);

    // R3: preamble head
    assert_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_code && run_q == 3'd0) |-> out_byte == PRE_HEAD);

    // R3: preamble fill bytes
    assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_code && (run_q == 3'd1 || run_q == 3'd2)) |-> out_byte == PRE_FILL);

    // R3: marker never longer than four slots
    assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q == 3'd4 |-> !out_is_code);

    // R3: marker never shorter than four slots
    assert_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_is_code && run_q != 3'd0) |-> run_q == 3'd4);

    // R6, R7, R8: final byte is one of the legal code values
    assert_val_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_code && run_q == 3'd3) |->
            (out_byte <= 8'h03) || (out_byte[7:6] == 2'b10 && out_byte[3:0] == 4'h0));

    // R9: a marker only starts while insertion is latched on
    assert_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_is_code) |-> $past(en_q));

endmodule

bind sci_top sci_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_byte    (in_byte),
    .out_byte   (out_byte),
    .out_is_code(out_is_code),
    .en_q       (en_lat)
);

// File: tb/sci_top_tb.sv
`timescale 1ns/1ps
module sci_top_tb;

    localparam int MAXS = 8192;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_byte;
    logic       in_win, in_act_line, in_first_line, in_last_line;
    logic       frame_sync, cfg_ins_en, cfg_mode_flag;
    logic [7:0] out_byte;
    logic       out_is_code;

    always #2.5 clk = ~clk;

    sci_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_byte      (in_byte),
        .in_win       (in_win),
        .in_act_line  (in_act_line),
        .in_first_line(in_first_line),
        .in_last_line (in_last_line),
        .frame_sync   (frame_sync),
        .cfg_ins_en   (cfg_ins_en),
        .cfg_mode_flag(cfg_mode_flag),
        .out_byte     (out_byte),
        .out_is_code  (out_is_code)
    );

    logic [7:0] a_byte [MAXS];
    bit a_win [MAXS], a_line [MAXS], a_first [MAXS], a_last [MAXS];
    bit a_en [MAXS], a_sel [MAXS], a_junk [MAXS];

    int n_chk = 0;
    int n_bad = 0;
    int nslot = 0;
    bit cur_en = 1'b0;
    bit cur_sel = 1'b0;
    bit done = 1'b0;

    task automatic report(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Expected output for driven slot m, from window edges around it.
    task automatic exp_at(input int m, output logic [7:0] eb, output bit ef, output string tag);
        eb  = a_byte[m];
        ef  = 1'b0;
        tag = a_en[m] ? "R2" : "R9";
        for (int d = 1; d <= 4; d++) begin
            int s = m + d;
            if (s >= 1 && a_win[s] && !a_win[s-1] && a_en[s] && (a_sel[s] || a_line[s])) begin
                int k = 4 - d;
                ef = 1'b1;
                if (k == 0)      begin eb = 8'hFF; tag = "R3 R4"; end
                else if (k < 3)  begin eb = 8'h00; tag = "R3 R4"; end
                else if (a_sel[s]) begin eb = a_line[s] ? 8'h80 : 8'hA0; tag = "R8 R4"; end
                else if (a_first[s]) begin eb = 8'h02; tag = "R7 R4"; end
                else             begin eb = 8'h00; tag = "R6 R4"; end
            end
        end
        for (int d = 1; d <= 4; d++) begin
            int k = m - d;
            if (k >= 0 && a_win[k] && !a_win[k+1] && a_en[k] && (a_sel[k] || a_line[k])) begin
                ef = 1'b1;
                if (d == 1)      begin eb = 8'hFF; tag = "R3 R5"; end
                else if (d < 4)  begin eb = 8'h00; tag = "R3 R5"; end
                else if (a_sel[k]) begin eb = a_line[k] ? 8'h90 : 8'hB0; tag = "R8 R5"; end
                else if (a_last[k]) begin eb = 8'h03; tag = "R7 R5"; end
                else             begin eb = 8'h01; tag = "R6 R5"; end
            end
        end
        if (a_junk[m]) tag = {tag, " R10"};
    endtask

    task automatic step(input logic [7:0] b, input bit w, input bit ln, input bit fst,
                        input bit lst, input bit sync, input bit se, input bit ss);
        logic [7:0] eb;
        bit         ef;
        string      tag;
        @(negedge clk);
        if (nslot >= 5) begin
            exp_at(nslot - 5, eb, ef, tag);
            report(out_byte == eb, tag, out_byte, eb);
            report(out_is_code == ef, {tag, " flag"}, {7'd0, out_is_code}, {7'd0, ef});
        end
        if (nslot < MAXS) begin
            in_byte       = b;
            in_win        = w;
            in_act_line   = ln;
            in_first_line = fst;
            in_last_line  = lst;
            frame_sync    = sync;
            // R10: settings wander between sync pulses
            cfg_ins_en    = sync ? se : 1'($urandom_range(0, 1));
            cfg_mode_flag = sync ? ss : 1'($urandom_range(0, 1));
            a_byte[nslot]  = b;
            a_win[nslot]   = w;
            a_line[nslot]  = ln;
            a_first[nslot] = fst;
            a_last[nslot]  = lst;
            a_en[nslot]    = cur_en;
            a_sel[nslot]   = cur_sel;
            a_junk[nslot]  = (cfg_ins_en != cur_en) || (cfg_mode_flag != cur_sel);
            if (sync) begin
                cur_en  = se;
                cur_sel = ss;
            end
            nslot++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(8'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic one_line(input int pre, input int w, input int post,
                            input bit ln, input bit fst, input bit lst);
        for (int i = 0; i < pre; i++)  step(8'($urandom), 1'b0, ln, fst, lst, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < w; i++)    step(8'($urandom), 1'b1, ln, fst, lst, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < post; i++) step(8'($urandom), 1'b0, ln, fst, lst, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic frame(input bit en, input bit sel, input int ntop, input int nact,
                         input int nbot, input int wmin, input int wmax);
        idle(6);
        step(8'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, en, sel);
        idle(6);
        for (int l = 0; l < ntop; l++)
            one_line($urandom_range(4, 7), $urandom_range(wmin, wmax), $urandom_range(5, 8), 1'b0, 1'b0, 1'b0);
        for (int l = 0; l < nact; l++)
            one_line($urandom_range(4, 7), $urandom_range(wmin, wmax), $urandom_range(5, 8),
                     1'b1, l == 0, l == nact - 1);
        for (int l = 0; l < nbot; l++)
            one_line($urandom_range(4, 7), $urandom_range(wmin, wmax), $urandom_range(5, 8), 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        in_byte = 8'h5A; in_win = 1'b0; in_act_line = 1'b0;
        in_first_line = 1'b0; in_last_line = 1'b0;
        frame_sync = 1'b0; cfg_ins_en = 1'b1; cfg_mode_flag = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state
        report(out_byte == 8'h00, "R1 byte", out_byte, 8'h00);
        report(out_is_code == 1'b0, "R1 flag", {7'd0, out_is_code}, 8'h00);
        in_byte = 8'h00;
        rst_n = 1'b1;

        frame(1'b1, 1'b0, 2, 3, 2, 4, 10);   // R6, R7 compact style
        frame(1'b1, 1'b0, 1, 1, 1, 1, 1);    // R7 single active line, one-byte windows
        frame(1'b1, 1'b1, 2, 3, 2, 4, 10);   // R8 flagged style on all lines
        frame(1'b0, 1'b1, 1, 2, 1, 3, 8);    // R9 disabled
        frame(1'b1, 1'b1, 1, 1, 1, 1, 1);    // R8 with one-byte windows
        for (int f = 0; f < 9; f++)
            frame($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)),
                  $urandom_range(1, 2), $urandom_range(1, 4), $urandom_range(1, 2), 1, 12);
        idle(12);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule